// File: doc/BRIEF.md
# Instruction Address Sequencer

This block keeps the packed 26-bit instruction-address word of a small sequential processor and works out its next value once per instruction step. The word holds several fields at fixed bit positions: the instruction module, the instruction sector, the syllable select, the 8-bit location, and the data environment (data module, data sector and two duplex flags). The block splits the word into these fields and presents them as fetch-address outputs. It also decodes the 13-bit instruction word it is handed, so that it can pick among sequential flow, unconditional or conditional transfer, reload of the whole word from memory, and a change of data environment.

A core wrapper presents the fetched instruction, the current accumulator and any memory word needed for a reload, and then pulses `step` for one cycle. The new address word is visible one cycle later. A one-cycle interrupt-inhibit flag marks every step that broke sequential flow. A return-address word (the current address with its location advanced) is available at all times, so a subroutine call can store it. A reload word that is badly formed is refused and reported.

Top module: `instr_addr_seq`

## Requirements
- R1: A synchronous reset loads the address word with the parameter START_WORD and clears intr_inhibit and fmt_err.
- R2: In any cycle where step is low the address word holds its value, and intr_inhibit and fmt_err read zero in the following cycle.
- R3: The outputs show the fields of the address word: location = bits 14:7, syllable = bit 6, instruction sector = bits 5:2, instruction module = {bits 1:0, bit 25} (bit 25 is the LSB), data-duplex = bit 16, data module = bits 19:17, data sector = bits 23:20, instruction-duplex = bit 24.
- R4: A step whose instruction is not taken as a transfer, reload or data change advances the location by one. Location 255 stays at 255. Every other field is left unchanged.
- R5: The instruction word has opcode = bits 3:0, residual = bit 4 and operand = bits 12:5. Opcode 8 sets location to the operand and syllable to the residual, with every other field left unchanged.
- R6: Opcode 4 branches as in R5 when the 26-bit accumulator is nonzero, and otherwise steps as in R4.
- R7: Opcode 12 branches as in R5 when accumulator bit 25 is one, and otherwise steps as in R4.
- R8: Opcode 0 replaces the whole address word with mem_word.
- R9: If the reload word of opcode 0 has bit 15 set, the address word is not changed and fmt_err is high for exactly the next cycle.
- R10: Opcode 14 with residual 0 and operand bit 7 equal to 0 sets data module = operand bits 3:1, data sector = operand bits 7:4 and data-duplex = operand bit 0. The location then advances as in R4.
- R11: intr_inhibit is high for exactly the cycle after a step that made a taken branch or an accepted reload, and is low otherwise.
- R12: return_word equals the current address word with its location advanced as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | One-cycle strobe that advances the sequencer |
| instr | input | 13 | Current instruction word |
| acc | input | 26 | Accumulator value for conditional transfers |
| mem_word | input | 26 | Memory word used by a reload |
| addr_word | output | 26 | Packed address register |
| fetch_imod | output | 3 | Instruction module |
| fetch_isec | output | 4 | Instruction sector |
| fetch_syl | output | 1 | Syllable select |
| fetch_loc | output | 8 | Location |
| data_mod | output | 3 | Data module |
| data_sec | output | 4 | Data sector |
| data_dup | output | 1 | Data-duplex flag |
| instr_dup | output | 1 | Instruction-duplex flag |
| intr_inhibit | output | 1 | Interrupt-inhibit pulse after a flow break |
| fmt_err | output | 1 | Pulse after a refused reload |
| return_word | output | 26 | Current address with location advanced |

## Verification
Within one step, the data-environment change and the location increment both act on the same word. The same holds for a branch and a change of syllable. The sweep therefore drives every opcode and residual with operands at 0, 127, 128, 254 and 255, and starts from a location that has been parked at 255. In that state the field rewrite and the saturation happen together, and the whole repacked word is compared with a model that works out every field by division and remainder. The two conditional opcodes are each driven with accumulators that are zero, positive, negative and both nonzero and negative. This separates the nonzero test from the sign test in the same cycle.

// File: rtl/iaseq_pkg.sv
package iaseq_pkg;
  localparam int WORD_W  = 26;
  localparam int INSTR_W = 13;
  localparam int OP_W    = 4;
  localparam int LOC_W   = 8;
  localparam int ERR_BIT = 15;
  localparam logic [LOC_W-1:0] LOC_TOP = {LOC_W{1'b1}};

  localparam logic [OP_W-1:0] OP_RELOAD = 4'h0;
  localparam logic [OP_W-1:0] OP_TNZ    = 4'h4;
  localparam logic [OP_W-1:0] OP_TRA    = 4'h8;
  localparam logic [OP_W-1:0] OP_TMI    = 4'hC;
  localparam logic [OP_W-1:0] OP_DENV   = 4'hE;

  typedef enum logic [2:0] {
    K_SEQ, K_TRA, K_TNZ, K_TMI, K_LOAD, K_DENV
  } op_kind_t;

  typedef struct packed {
    logic             idup;
    logic [3:0]       dsec;
    logic [2:0]       dmod;
    logic             ddup;
    logic [LOC_W-1:0] loc;
    logic             syl;
    logic [3:0]       isec;
    logic [2:0]       imod;
  } addr_fields_t;

  function automatic addr_fields_t unpack_word(input logic [WORD_W-1:0] w);
    addr_fields_t f;
    f.imod = {w[1:0], w[25]};
    f.isec = w[5:2];
    f.syl  = w[6];
    f.loc  = w[14:7];
    f.ddup = w[16];
    f.dmod = w[19:17];
    f.dsec = w[23:20];
    f.idup = w[24];
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input addr_fields_t f);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[25]    = f.imod[0];
    w[1:0]   = f.imod[2:1];
    w[5:2]   = f.isec;
    w[6]     = f.syl;
    w[14:7]  = f.loc;
    w[16]    = f.ddup;
    w[19:17] = f.dmod;
    w[23:20] = f.dsec;
    w[24]    = f.idup;
    return w;
  endfunction

  function automatic logic [LOC_W-1:0] loc_advance(input logic [LOC_W-1:0] l);
    return (l == LOC_TOP) ? l : l + 1'b1;
  endfunction
endpackage

// File: rtl/iaseq_decode.sv
module iaseq_decode
  import iaseq_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output op_kind_t           kind,
  output logic [LOC_W-1:0]   operand,
  output logic               residual
);
  logic [OP_W-1:0] opcode;

  assign opcode   = instr[OP_W-1:0];
  assign residual = instr[OP_W];
  assign operand  = instr[INSTR_W-1:OP_W+1];

  always_comb begin
    case (opcode)
      OP_RELOAD: kind = K_LOAD;
      OP_TRA:    kind = K_TRA;
      OP_TNZ:    kind = K_TNZ;
      OP_TMI:    kind = K_TMI;
      OP_DENV:   kind = (!operand[LOC_W-1] && !residual) ? K_DENV : K_SEQ;
      default:   kind = K_SEQ;
    endcase
  end
endmodule

// File: rtl/iaseq_next.sv
module iaseq_next
  import iaseq_pkg::*;
(
  input  logic [WORD_W-1:0] cur_word,
  input  op_kind_t          kind,
  input  logic [LOC_W-1:0]  operand,
  input  logic              residual,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] mem_word,
  output logic [WORD_W-1:0] next_word,
  output logic              branch_taken,
  output logic              reload_ok,
  output logic              reload_bad
);
  logic acc_nonzero;
  logic acc_negative;
  addr_fields_t f;

  assign acc_nonzero  = |acc;
  assign acc_negative = acc[WORD_W-1];

  always_comb begin
    case (kind)
      K_TRA:   branch_taken = 1'b1;
      K_TNZ:   branch_taken = acc_nonzero;
      K_TMI:   branch_taken = acc_negative;
      default: branch_taken = 1'b0;
    endcase
  end

  assign reload_ok  = (kind == K_LOAD) && !mem_word[ERR_BIT];
  assign reload_bad = (kind == K_LOAD) &&  mem_word[ERR_BIT];

  always_comb begin
    f = unpack_word(cur_word);
    if (branch_taken) begin
      f.loc = operand;
      f.syl = residual;
    end else begin
      f.loc = loc_advance(f.loc);
    end
    if (kind == K_DENV) begin
      f.dmod = operand[3:1];
      f.dsec = operand[7:4];
      f.ddup = operand[0];
    end
    next_word = (kind == K_LOAD) ? mem_word : pack_word(f);
  end
endmodule

// File: rtl/instr_addr_seq.sv
module instr_addr_seq
  import iaseq_pkg::*;
#(
  parameter logic [WORD_W-1:0] START_WORD = 26'd0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic [INSTR_W-1:0] instr,
  input  logic [WORD_W-1:0]  acc,
  input  logic [WORD_W-1:0]  mem_word,
  output logic [WORD_W-1:0]  addr_word,
  output logic [2:0]         fetch_imod,
  output logic [3:0]         fetch_isec,
  output logic               fetch_syl,
  output logic [LOC_W-1:0]   fetch_loc,
  output logic [2:0]         data_mod,
  output logic [3:0]         data_sec,
  output logic               data_dup,
  output logic               instr_dup,
  output logic               intr_inhibit,
  output logic               fmt_err,
  output logic [WORD_W-1:0]  return_word
);
  op_kind_t          kind;
  logic [LOC_W-1:0]  operand;
  logic              residual;
  logic [WORD_W-1:0] next_word;
  logic              branch_taken;
  logic              reload_ok;
  logic              reload_bad;
  logic [WORD_W-1:0] addr_q;
  logic              inh_q;
  logic              err_q;
  addr_fields_t      cur_f;
  addr_fields_t      ret_f;

  // named step events
  logic ev_flow_break;
  logic ev_reject;
  logic ev_update;

  iaseq_decode u_decode (
    .instr    (instr),
    .kind     (kind),
    .operand  (operand),
    .residual (residual)
  );

  iaseq_next u_next (
    .cur_word     (addr_q),
    .kind         (kind),
    .operand      (operand),
    .residual     (residual),
    .acc          (acc),
    .mem_word     (mem_word),
    .next_word    (next_word),
    .branch_taken (branch_taken),
    .reload_ok    (reload_ok),
    .reload_bad   (reload_bad)
  );

  assign ev_flow_break = step && (branch_taken || reload_ok);
  assign ev_reject     = step && reload_bad;
  assign ev_update     = step && !reload_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= START_WORD;
      inh_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      inh_q <= ev_flow_break;
      err_q <= ev_reject;
      if (ev_update) addr_q <= next_word;
    end
  end

  always_comb begin
    cur_f     = unpack_word(addr_q);
    ret_f     = cur_f;
    ret_f.loc = loc_advance(cur_f.loc);
  end

  assign addr_word    = addr_q;
  assign fetch_imod   = cur_f.imod;
  assign fetch_isec   = cur_f.isec;
  assign fetch_syl    = cur_f.syl;
  assign fetch_loc    = cur_f.loc;
  assign data_mod     = cur_f.dmod;
  assign data_sec     = cur_f.dsec;
  assign data_dup     = cur_f.ddup;
  assign instr_dup    = cur_f.idup;
  assign intr_inhibit = inh_q;
  assign fmt_err      = err_q;
  assign return_word  = pack_word(ret_f);
endmodule

// File: rtl/iaseq_chk.sv
module iaseq_chk (
  input logic        clk,
  input logic        rst,
  input logic        step,
  input logic [12:0] instr,
  input logic [25:0] addr_word,
  input logic [7:0]  fetch_loc,
  input logic        fetch_syl,
  input logic        intr_inhibit,
  input logic        fmt_err
);
  a_r2_hold_without_step: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(addr_word));

  a_r11_inhibit_needs_step: assert property (@(posedge clk) disable iff (rst)
    !step |=> !intr_inhibit);

  a_r9_reject_keeps_word: assert property (@(posedge clk) disable iff (rst)
    fmt_err |-> $stable(addr_word));

  a_r9_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(fmt_err && intr_inhibit));

  a_r4_loc_saturates: assert property (@(posedge clk) disable iff (rst)
    (step && instr[3:0] == 4'h2 && fetch_loc == 8'hFF) |=> fetch_loc == 8'hFF);

  a_r5_transfer_target: assert property (@(posedge clk) disable iff (rst)
    (step && instr[3:0] == 4'h8) |=>
      (fetch_loc == $past(instr[12:5]) && fetch_syl == $past(instr[4]) && intr_inhibit));
endmodule

bind instr_addr_seq iaseq_chk u_iaseq_chk (
  .clk          (clk),
  .rst          (rst),
  .step         (step),
  .instr        (instr),
  .addr_word    (addr_word),
  .fetch_loc    (fetch_loc),
  .fetch_syl    (fetch_syl),
  .intr_inhibit (intr_inhibit),
  .fmt_err      (fmt_err)
);

// File: tb/test_instr_addr_seq.sv
module test_instr_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic [12:0] instr = '0;
  logic [25:0] acc = '0;
  logic [25:0] mem_word = '0;
  logic [25:0] addr_word;
  logic [2:0]  fetch_imod;
  logic [3:0]  fetch_isec;
  logic        fetch_syl;
  logic [7:0]  fetch_loc;
  logic [2:0]  data_mod;
  logic [3:0]  data_sec;
  logic        data_dup;
  logic        instr_dup;
  logic        intr_inhibit;
  logic        fmt_err;
  logic [25:0] return_word;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;
  int model;
  int seed = 32'h1234_5677;

  instr_addr_seq i_instr_addr_seq (
    .clk(clk), .rst(rst), .step(step), .instr(instr), .acc(acc),
    .mem_word(mem_word), .addr_word(addr_word), .fetch_imod(fetch_imod),
    .fetch_isec(fetch_isec), .fetch_syl(fetch_syl), .fetch_loc(fetch_loc),
    .data_mod(data_mod), .data_sec(data_sec), .data_dup(data_dup),
    .instr_dup(instr_dup), .intr_inhibit(intr_inhibit), .fmt_err(fmt_err),
    .return_word(return_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WDOG_CYCLES && !finished) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WDOG_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int nxt(input int s);
    int x;
    x = s ^ (s << 13);
    x = x ^ (x >>> 17) & 32'h0000_7FFF;
    x = x ^ (x << 5);
    return x;
  endfunction

  // field arithmetic written as division and remainder
  function automatic int fld(input int w, input int scale, input int span);
    return (w / scale) % span;
  endfunction
  function automatic int put(input int w, input int scale, input int span, input int v);
    return w - fld(w, scale, span) * scale + v * scale;
  endfunction
  function automatic int adv(input int w);
    int l;
    l = fld(w, 128, 256);
    return (l < 255) ? put(w, 128, 256, l + 1) : w;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_fields(input string tag);
    chk({tag, " word"}, int'(addr_word), model);
    chk("R3 loc", int'(fetch_loc), fld(model, 128, 256));
    chk("R3 syl", int'(fetch_syl), fld(model, 64, 2));
    chk("R3 isec", int'(fetch_isec), fld(model, 4, 16));
    chk("R3 imod", int'(fetch_imod), fld(model, 1, 4) * 2 + fld(model, 33554432, 2));
    chk("R3 ddup", int'(data_dup), fld(model, 65536, 2));
    chk("R3 dmod", int'(data_mod), fld(model, 131072, 8));
    chk("R3 dsec", int'(data_sec), fld(model, 1048576, 16));
    chk("R3 idup", int'(instr_dup), fld(model, 16777216, 2));
    chk("R12 return", int'(return_word), adv(model));
  endtask

  // apply one step; the result is sampled one cycle after the strobe
  task automatic do_step(input int op, input int res, input int opd,
                         input int a, input int m);
    string tag;
    int exp_inh, exp_err;
    bit take;
    instr = 13'(opd * 32 + res * 16 + op);
    acc = 26'(a);
    mem_word = 26'(m);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    exp_inh = 0; exp_err = 0; take = 0; tag = "R4";
    if (op == 0) begin
      tag = "R8";
      if (fld(m, 32768, 2) == 1) begin exp_err = 1; tag = "R9"; end
      else begin model = m; exp_inh = 1; end
    end else begin
      if (op == 8) begin take = 1; tag = "R5"; end
      if (op == 4) begin take = (a != 0); tag = "R6"; end
      if (op == 12) begin take = (a >= 33554432); tag = "R7"; end
      if (take) begin
        model = put(put(model, 128, 256, opd), 64, 2, res);
        exp_inh = 1;
      end else begin
        if (op == 14 && res == 0 && opd < 128) begin
          tag = "R10";
          model = put(model, 131072, 8, (opd / 2) % 8);
          model = put(model, 1048576, 16, opd / 16);
          model = put(model, 65536, 2, opd % 2);
        end
        model = adv(model);
      end
    end
    chk_fields(tag);
    chk("R11 inhibit", int'(intr_inhibit), exp_inh);
    chk("R9 fmt_err", int'(fmt_err), exp_err);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model = 0;
    chk_fields("R1");
    chk("R1 inhibit", int'(intr_inhibit), 0);
    chk("R1 fmt_err", int'(fmt_err), 0);
  endtask

  initial begin
    int opds[6];
    int accs[5];
    opds = '{0, 1, 127, 128, 254, 255};
    accs = '{0, 5, 33554432, 33554433, 12345};
    @(negedge clk);
    do_reset();

    // R2: no strobe, branch instruction present, nothing moves
    instr = 13'(77 * 32 + 8);
    acc = 26'd1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_fields("R2");
      chk("R2 inhibit", int'(intr_inhibit), 0);
    end

    // R4 saturation, then data change at the top location
    do_step(8, 1, 255, 0, 0);
    do_step(2, 0, 3, 0, 0);
    do_step(14, 0, 8'h5B, 0, 0);
    do_step(6, 0, 0, 0, 0);

    // sweep of opcode x residual x operand x accumulator
    for (int op = 0; op < 16; op++)
      for (int res = 0; res < 2; res++)
        for (int oi = 0; oi < 6; oi++)
          for (int ai = 0; ai < 5; ai++) begin
            int m;
            seed = nxt(seed);
            m = seed & 32'h03FF_FFFF;
            if (ai % 2 == 0) m = m & 32'h03FF_7FFF;
            else m = m | 32'h0000_8000;
            if (op == 0 && ai == 4) m = 32'h0000_7F80;
            do_step(op, res, opds[oi], accs[ai], m);
          end

    // mid-run reset returns to the start word
    do_step(8, 0, 42, 0, 0);
    do_reset();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule